// File: doc/BRIEF.md
# Leaky Loop Filter with Range Limiter

This block is the sampled loop filter of a clock-deskew delay-locked loop. On each rising clock edge it samples two request levels, `up_req` and `dn_req`, from a phase detector. It folds their difference into a signed control word, `ctrl_word`, which steers a voltage-controlled delay element. The two requests are treated as a differential pair. When both are high, or both are low, no step is applied, so matched detector pulses cancel.

The integration is deliberately lossy. On every update a leak term equal to the accumulator divided by 2^k, truncated toward zero, is removed, where k is `leak_shift`. This gives the filter a finite DC gain of about 2^k. For example, k = 8 gives a gain near 256, well above the minimum of 31 that the loop needs, and the lossy integration keeps the loop over-damped. The word saturates at its signed extremes rather than wrapping.

Two independent programmable thresholds watch the control word. `flag_hi` marks an excursion above the upper limit and `flag_lo` marks an excursion below the lower limit. The limits are set separately because the delay element reacts unequally to the two polarities. The flags feed a false-lock correction path outside this block. All pins are plain levels sampled or driven every cycle, with no stream handshake and no back-pressure: the block accepts a new request pair on every edge.

Top module: `leaky_loop_filter`

## Requirements
- R1: A synchronous active-high `rst` sets `ctrl_word` to 0 and drives `flag_hi` and `flag_lo` low on the next edge.
- R2: With `up_req`=1 and `dn_req`=0 the update adds +1 after the leak. With `dn_req`=1 and `up_req`=0 it adds -1.
- R3: With `up_req` equal to `dn_req` (both 0 or both 1) only the leak acts, so `ctrl_word` never grows in magnitude and stays unchanged when the leak term is zero.
- R4: Each update removes acc/2^k truncated toward zero, with k = `leak_shift`. For example, -7 with k=2 becomes -6 when no step applies.
- R5: Held UP from 0 settles at exactly +2^k and stays there. Held DOWN settles at exactly -2^k (for 2^k below the signed maximum).
- R6: `ctrl_word` saturates at 2^(W-1)-1 and -2^(W-1) and never wraps in sign.
- R7: `flag_hi` is 1 exactly when `ctrl_word` > `thr_hi` (signed, strict). It is updated on the same edge as `ctrl_word`, using the threshold sampled on that edge.
- R8: `flag_lo` is 1 exactly when `ctrl_word` < `thr_lo` (signed, strict), with `thr_lo` independent of `thr_hi`.
- R9: Both flags are 0 whenever `thr_lo` <= `ctrl_word` <= `thr_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Phase detector request to raise the control word |
| dn_req | input | 1 | Phase detector request to lower the control word |
| leak_shift | input | SHW | Leak shift k; the DC gain is about 2^k |
| thr_hi | input | W | Signed upper limit |
| thr_lo | input | W | Signed lower limit |
| ctrl_word | output | W | Signed control word for the delay element |
| flag_hi | output | 1 | Control word above the upper limit |
| flag_lo | output | 1 | Control word below the lower limit |

## Verification
Each result is due one rising edge after its inputs are sampled. The control word and both flags come from the same register stage, so the flags always describe the value shown alongside them. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, after exactly one rising edge has passed. It checks each sample against a value derived from the requirements, for example +2^k after a long UP run, and a strict threshold crossing at limit+1.

// File: rtl/llf_pkg.sv
package llf_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

endpackage

// File: rtl/llf_step_decode.sv
module llf_step_decode
  import llf_pkg::*;
(
  input  logic  up_req,
  input  logic  dn_req,
  output step_e step
);

  always_comb begin
    unique case ({up_req, dn_req})
      2'b10:   step = STEP_INC;
      2'b01:   step = STEP_DEC;
      default: step = STEP_HOLD;
    endcase
  end

endmodule

// File: rtl/llf_leak.sv
module llf_leak #(
  parameter int W   = 16,
  parameter int SHW = 4
) (
  input  logic [W-1:0]   acc,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   leak
);

  logic         neg;
  logic [W:0]   ext;
  logic [W:0]   mag;
  logic [W:0]   shifted;
  logic [W:0]   negated;

  always_comb begin
    neg     = acc[W-1];
    ext     = {acc[W-1], acc};
    mag     = neg ? (~ext + 1'b1) : ext;
    shifted = mag >> sh;
    negated = ~shifted + 1'b1;
    leak    = neg ? negated[W-1:0] : shifted[W-1:0];
  end

endmodule

// File: rtl/llf_sat_update.sv
module llf_sat_update
  import llf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] leak,
  input  step_e        step,
  output logic [W-1:0] nxt
);

  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((1 << (W - 1)) - 1);
  localparam logic signed [XW-1:0] MINV = -XW'(1 << (W - 1));

  logic signed [XW-1:0] acc_x;
  logic signed [XW-1:0] leak_x;
  logic signed [XW-1:0] step_x;
  logic signed [XW-1:0] sum_x;

  always_comb begin
    acc_x  = {{2{acc[W-1]}}, acc};
    leak_x = {{2{leak[W-1]}}, leak};
    unique case (step)
      STEP_INC: step_x = XW'(1);
      STEP_DEC: step_x = -XW'(1);
      default:  step_x = '0;
    endcase
    sum_x = acc_x - leak_x + step_x;
    if (sum_x > MAXV)      nxt = MAXV[W-1:0];
    else if (sum_x < MINV) nxt = MINV[W-1:0];
    else                   nxt = sum_x[W-1:0];
  end

endmodule

// File: rtl/llf_limit_cmp.sv
module llf_limit_cmp #(
  parameter int W     = 16,
  parameter bit ABOVE = 1'b1
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] thr,
  output logic         hit
);

  generate
    if (ABOVE) begin : g_above
      assign hit = $signed(val) > $signed(thr);
    end else begin : g_below
      assign hit = $signed(val) < $signed(thr);
    end
  endgenerate

endmodule

// File: rtl/leaky_loop_filter.sv
module leaky_loop_filter
  import llf_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           up_req,
  input  logic           dn_req,
  input  logic [SHW-1:0] leak_shift,
  input  logic [W-1:0]   thr_hi,
  input  logic [W-1:0]   thr_lo,
  output logic [W-1:0]   ctrl_word,
  output logic           flag_hi,
  output logic           flag_lo
);

  step_e        step;
  logic [W-1:0] leak;
  logic [W-1:0] acc_nxt;
  logic         hi_nxt;
  logic         lo_nxt;
  logic [W-1:0] acc_q;
  logic         hi_q;
  logic         lo_q;

  llf_step_decode u_dec (
    .up_req (up_req),
    .dn_req (dn_req),
    .step   (step)
  );

  llf_leak #(.W(W), .SHW(SHW)) u_leak (
    .acc  (acc_q),
    .sh   (leak_shift),
    .leak (leak)
  );

  llf_sat_update #(.W(W)) u_upd (
    .acc  (acc_q),
    .leak (leak),
    .step (step),
    .nxt  (acc_nxt)
  );

  llf_limit_cmp #(.W(W), .ABOVE(1'b1)) u_cmp_hi (
    .val (acc_nxt),
    .thr (thr_hi),
    .hit (hi_nxt)
  );

  llf_limit_cmp #(.W(W), .ABOVE(1'b0)) u_cmp_lo (
    .val (acc_nxt),
    .thr (thr_lo),
    .hit (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      hi_q  <= hi_nxt;
      lo_q  <= lo_nxt;
    end
  end

  assign ctrl_word = acc_q;
  assign flag_hi   = hi_q;
  assign flag_lo   = lo_q;

endmodule

// File: rtl/llf_checker.sv
module llf_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         up_req,
  input logic         dn_req,
  input logic [W-1:0] thr_hi,
  input logic [W-1:0] thr_lo,
  input logic [W-1:0] ctrl_word,
  input logic         flag_hi,
  input logic         flag_lo
);

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  function automatic logic [W:0] absval(input logic [W-1:0] v);
    logic [W:0] e;
    e = {v[W-1], v};
    return v[W-1] ? (~e + 1'b1) : e;
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    primed && $past(rst) |-> (ctrl_word == '0) && !flag_hi && !flag_lo);

  // R3
  cm_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(up_req == dn_req) |-> absval(ctrl_word) <= absval($past(ctrl_word)));

  // R6
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
    primed && ($signed($past(ctrl_word)) > 1) && $past(!dn_req || up_req) |-> !ctrl_word[W-1]);

  // R6
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
    primed && ($signed($past(ctrl_word)) < -1) && $past(!up_req || dn_req) |-> ($signed(ctrl_word) <= 0));

  // R7
  hi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) |-> flag_hi == ($signed(ctrl_word) > $signed($past(thr_hi))));

  // R8
  lo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) |-> flag_lo == ($signed(ctrl_word) < $signed($past(thr_lo))));

endmodule

bind leaky_loop_filter llf_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .up_req    (up_req),
  .dn_req    (dn_req),
  .thr_hi    (thr_hi),
  .thr_lo    (thr_lo),
  .ctrl_word (ctrl_word),
  .flag_hi   (flag_hi),
  .flag_lo   (flag_lo)
);

// File: tb/leaky_loop_filter_test.sv
module leaky_loop_filter_test;

  localparam int W   = 10;
  localparam int SHW = 4;
  localparam int MAXV = (1 << (W - 1)) - 1;
  localparam int MINV = -(1 << (W - 1));

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           up_req = 1'b0;
  logic           dn_req = 1'b0;
  logic [SHW-1:0] leak_shift = '0;
  logic [W-1:0]   thr_hi = W'(100);
  logic [W-1:0]   thr_lo = W'(-100);
  logic [W-1:0]   ctrl_word;
  logic           flag_hi;
  logic           flag_lo;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  leaky_loop_filter #(.W(W), .SHW(SHW)) uut (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
    .leak_shift(leak_shift), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .ctrl_word(ctrl_word), .flag_hi(flag_hi), .flag_lo(flag_lo)
  );

  function automatic int next_val(int a, bit u, bit d, int k);
    int l;
    int s;
    l = (a < 0) ? -((-a) >>> k) : (a >>> k);
    s = a - l + ((u && !d) ? 1 : 0) - ((d && !u) ? 1 : 0);
    if (s > MAXV) s = MAXV;
    if (s < MINV) s = MINV;
    return s;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sval(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // one update: drive on falling edge, result after one rising edge
  task automatic tick(bit u, bit d, string tag, bit chk_word);
    up_req = u;
    dn_req = d;
    @(posedge clk);
    @(negedge clk);
    model = next_val(model, u, d, int'(leak_shift));
    if (chk_word) check(tag, "ctrl_word", sval(ctrl_word), model);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    up_req = 1'b0;
    dn_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "ctrl_word", sval(ctrl_word), 0);
    check("R1", "flag_hi", int'(flag_hi), 0);
    check("R1", "flag_lo", int'(flag_lo), 0);
  endtask

  task automatic t_steps();
    do_reset();
    leak_shift = 4'd15;
    for (int i = 0; i < 5; i++) tick(1, 0, "R2", 1);
    check("R2", "after 5 up", sval(ctrl_word), 5);
    for (int i = 0; i < 3; i++) tick(0, 1, "R2", 1);
    check("R2", "after 3 down", sval(ctrl_word), 2);
    for (int i = 0; i < 4; i++) tick(1, 1, "R3", 1);
    check("R3", "both high", sval(ctrl_word), 2);
    for (int i = 0; i < 4; i++) tick(0, 0, "R3", 1);
    check("R3", "both low", sval(ctrl_word), 2);
  endtask

  task automatic t_leak();
    do_reset();
    leak_shift = 4'd15;
    for (int i = 0; i < 7; i++) tick(0, 1, "R4", 0);
    check("R4", "at -7", sval(ctrl_word), -7);
    leak_shift = 4'd2;
    tick(0, 0, "R4", 0);
    check("R4", "-7 leaks to", sval(ctrl_word), -6);
    for (int i = 0; i < 6; i++) tick(1, 1, "R4", 1);
    leak_shift = 4'd15;
    for (int i = 0; i < 40; i++) tick(1, 0, "R4", 0);
    leak_shift = 4'd3;
    for (int i = 0; i < 8; i++) tick(0, 0, "R4", 1);
    leak_shift = 4'd0;
    tick(0, 1, "R4", 0);
    check("R4", "k=0 down", sval(ctrl_word), -1);
  endtask

  task automatic t_gain();
    do_reset();
    leak_shift = 4'd4;
    for (int i = 0; i < 40; i++) tick(1, 0, "R5", 0);
    check("R5", "settle up", sval(ctrl_word), 16);
    for (int i = 0; i < 80; i++) tick(0, 1, "R5", 0);
    check("R5", "settle down", sval(ctrl_word), -16);
    leak_shift = 4'd6;
    for (int i = 0; i < 200; i++) tick(1, 0, "R5", 0);
    check("R5", "settle up k6", sval(ctrl_word), 64);
  endtask

  task automatic t_sat();
    do_reset();
    leak_shift = 4'd15;
    for (int i = 0; i < 600; i++) tick(1, 0, "R6", 0);
    check("R6", "top", sval(ctrl_word), MAXV);
    for (int i = 0; i < 1200; i++) tick(0, 1, "R6", 0);
    check("R6", "bottom", sval(ctrl_word), MINV);
    tick(0, 1, "R6", 1);
  endtask

  task automatic t_flags();
    do_reset();
    leak_shift = 4'd15;
    thr_hi = W'(20);
    thr_lo = W'(-30);
    for (int i = 0; i < 20; i++) tick(1, 0, "R9", 0);
    check("R9", "hi at limit", int'(flag_hi), 0);
    check("R9", "lo at limit", int'(flag_lo), 0);
    tick(1, 0, "R7", 0);
    check("R7", "hi above", int'(flag_hi), 1);
    check("R7", "word", sval(ctrl_word), 21);
    thr_hi = W'(25);
    tick(0, 0, "R7", 0);
    check("R7", "hi new thr", int'(flag_hi), 0);
    for (int i = 0; i < 51; i++) tick(0, 1, "R9", 0);
    check("R9", "lo at limit", int'(flag_lo), 0);
    check("R9", "hi inside", int'(flag_hi), 0);
    check("R8", "word", sval(ctrl_word), -30);
    tick(0, 1, "R8", 0);
    check("R8", "lo below", int'(flag_lo), 1);
    check("R8", "hi stays low", int'(flag_hi), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_steps();
    t_leak();
    t_gain();
    t_sat();
    t_flags();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule